// File: doc/BRIEF.md
# Read-Before-Write Memory Monitor

This block sits beside a byte-addressed RAM port and reports every read of a byte that has not been stored to since the last clear. It keeps one shadow flag per byte, but only for a bounded window that starts at address zero. A store inside the window sets that byte's flag. A load inside the window whose flag is still clear produces a one-cycle warning. The warning carries the load address and the program-counter value presented with the load. The RAM data itself does not pass through the monitor.

The shadow flags are packed into wide words and are wiped by a sweep that clears one word per cycle. The sweep starts when reset is released and whenever a clear is requested, and it raises a busy flag while it runs. While the sweep is active, accesses are neither checked nor recorded. A static enable input turns the whole feature on. While enable is low, nothing is recorded and no warnings are raised.

Top module: `rbw_monitor`

## Requirements
- R1: Only addresses below `TRACK_LIMIT` (default 0x1F800) are tracked. A load at or above the limit never warns, and a store there marks nothing.
- R2: A store to a tracked address marks that byte, and a later load of the same byte raises no warning.
- R3: A load of a tracked, unmarked byte sets `warn` during the cycle after the clock edge that sampled the load. In that cycle `warnAddr` holds the load address and `warnPc` holds the `pc` sampled with it.
- R4: Both edges of the window are tracked: address 0 and address `TRACK_LIMIT-1` warn when unmarked and stop warning once stored to.
- R5: While `enable` is low, no warning is raised and stores mark nothing. A byte stored to while disabled still warns after enable is raised.
- R6: Reset holds `warn` low and `warnAddr`/`warnPc` at zero. After reset is released, `busy` stays high for exactly `TRACK_LIMIT/WORD_W` cycles. Afterwards every tracked byte is unmarked.
- R7: A one-cycle `clrReq` (sampled while idle) raises `busy` for exactly `TRACK_LIMIT/WORD_W` cycles from the next cycle and unmarks every byte. Loads and stores made while `busy` is high are neither checked nor recorded.
- R8: A load and a store to the same tracked address in the same cycle count as store-first. No warning is raised, and the byte is marked afterwards.
- R9: `warn` is high for one cycle per offending load. `warnAddr` and `warnPc` keep their values until the next warning.
- R10: Marking is per byte: a store marks neither neighbour, even when the neighbour shares a shadow word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| enable | input | 1 | Static feature enable |
| clrReq | input | 1 | Request to unmark every tracked byte |
| rdEn | input | 1 | Load strobe |
| rdAddr | input | ADDR_W | Load byte address |
| wrEn | input | 1 | Store strobe |
| wrAddr | input | ADDR_W | Store byte address |
| pc | input | PC_W | Program-counter tag presented with the access |
| busy | output | 1 | Clearing sweep in progress |
| warn | output | 1 | One-cycle warning pulse |
| warnAddr | output | ADDR_W | Address of the most recent offending load |
| warnPc | output | PC_W | Program-counter tag of the most recent offending load |

## Verification
The properties assume that reset is asserted at time zero. They also assume that `enable` is changed only between accesses. The stimulus therefore holds `rst` high for the first cycles, drives every input half a cycle away from the sampling edge, and moves `enable` only during idle cycles. Load and store addresses in the stimulus include both sides of the window limit. They also include same-cycle store and load collisions and bytes that share a shadow word. A random phase keeps addresses inside one shadow word and a few neighbours, so that reads often hit bytes that were never stored to.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
  localparam int MAX_IDX_W = 16;

  typedef struct packed {
    logic                 sweepEn;
    logic [MAX_IDX_W-1:0] sweepIdx;
    logic                 trackOn;
  } rbwCtl_t;
endpackage

// File: rtl/rbw_ctrl.sv
module rbw_ctrl #(
  parameter int NWORDS = 2016
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            clrReq,
  output logic            busy,
  output rbw_pkg::rbwCtl_t ctl
);
  import rbw_pkg::*;

  localparam logic [MAX_IDX_W-1:0] LAST_IDX = MAX_IDX_W'(NWORDS - 1);

  logic                 sweeping;
  logic [MAX_IDX_W-1:0] sweepCnt;

  always_ff @(posedge clk) begin
    if (rst || clrReq) begin
      sweeping <= 1'b1;
      sweepCnt <= '0;
    end else if (sweeping) begin
      if (sweepCnt == LAST_IDX) sweeping <= 1'b0;
      sweepCnt <= sweepCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.sweepEn  = sweeping;
    ctl.sweepIdx = sweepCnt;
    ctl.trackOn  = enable && !sweeping;
    busy         = sweeping;
  end
endmodule

// File: rtl/rbw_datapath.sv
module rbw_datapath #(
  parameter int ADDR_W      = 20,
  parameter int PC_W        = 16,
  parameter int TRACK_LIMIT = 'h1F800,
  parameter int WORD_W      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  rbw_pkg::rbwCtl_t  ctl,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PC_W-1:0]   pc,
  output logic              warn,
  output logic [ADDR_W-1:0] warnAddr,
  output logic [PC_W-1:0]   warnPc
);
  import rbw_pkg::*;

  localparam int NWORDS = (TRACK_LIMIT + WORD_W - 1) / WORD_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(NWORDS);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(TRACK_LIMIT);

  logic [WORD_W-1:0] shadow [NWORDS];

  logic              rdHit, wrHit, collide, rdMarked, warnNext;
  logic [IDX_W-1:0]  rdIdx, wrIdx;
  logic [BIT_W-1:0]  rdBit, wrBit;

  always_comb begin
    rdIdx    = rdAddr[BIT_W +: IDX_W];
    rdBit    = rdAddr[BIT_W-1:0];
    wrIdx    = wrAddr[BIT_W +: IDX_W];
    wrBit    = wrAddr[BIT_W-1:0];
    rdHit    = ctl.trackOn && rdEn && (rdAddr < LIMIT);
    wrHit    = ctl.trackOn && wrEn && (wrAddr < LIMIT);
    collide  = wrHit && (wrAddr == rdAddr);
    rdMarked = shadow[rdIdx][rdBit];
    warnNext = rdHit && !rdMarked && !collide;
  end

  always_ff @(posedge clk) begin
    if (ctl.sweepEn && (ctl.sweepIdx < MAX_IDX_W'(NWORDS)))
      shadow[ctl.sweepIdx[IDX_W-1:0]] <= '0;
    else if (wrHit)
      shadow[wrIdx][wrBit] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn     <= 1'b0;
      warnAddr <= '0;
      warnPc   <= '0;
    end else begin
      warn <= warnNext;
      if (warnNext) begin
        warnAddr <= rdAddr;
        warnPc   <= pc;
      end
    end
  end
endmodule

// File: rtl/rbw_monitor.sv
module rbw_monitor #(
  parameter int ADDR_W      = 20,
  parameter int PC_W        = 16,
  parameter int TRACK_LIMIT = 'h1F800,
  parameter int WORD_W      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              clrReq,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PC_W-1:0]   pc,
  output logic              busy,
  output logic              warn,
  output logic [ADDR_W-1:0] warnAddr,
  output logic [PC_W-1:0]   warnPc
);
  localparam int NWORDS = (TRACK_LIMIT + WORD_W - 1) / WORD_W;

  rbw_pkg::rbwCtl_t ctl;

  rbw_ctrl #(.NWORDS(NWORDS)) i_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .clrReq(clrReq),
    .busy(busy), .ctl(ctl)
  );

  rbw_datapath #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .TRACK_LIMIT(TRACK_LIMIT), .WORD_W(WORD_W)
  ) i_datapath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr), .pc(pc),
    .warn(warn), .warnAddr(warnAddr), .warnPc(warnPc)
  );
endmodule

// File: rtl/rbw_checker.sv
module rbw_checker #(
  parameter int ADDR_W      = 20,
  parameter int PC_W        = 16,
  parameter int TRACK_LIMIT = 'h1F800
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              busy,
  input logic              warn,
  input logic [ADDR_W-1:0] warnAddr,
  input logic [PC_W-1:0]   warnPc
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(TRACK_LIMIT);

  assert_outside_window_R1: assert property (@(posedge clk) disable iff (rst)
    (rdEn && rdAddr >= LIMIT) |=> !warn);

  assert_warn_in_window_R1: assert property (@(posedge clk) disable iff (rst)
    warn |-> (warnAddr < LIMIT));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !warn);

  assert_reset_starts_sweep_R6: assert property (@(posedge clk)
    rst |=> busy);

  assert_sweep_unchecked_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !warn);

  assert_store_first_R8: assert property (@(posedge clk) disable iff (rst)
    (rdEn && wrEn && rdAddr == wrAddr) |=> !warn);

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    !warn |=> ($stable(warnAddr) && $stable(warnPc)) || warn);
endmodule

bind rbw_monitor rbw_checker #(
  .ADDR_W(ADDR_W), .PC_W(PC_W), .TRACK_LIMIT(TRACK_LIMIT)
) i_rbw_checker (
  .clk(clk), .rst(rst), .enable(enable), .rdEn(rdEn), .rdAddr(rdAddr),
  .wrEn(wrEn), .wrAddr(wrAddr), .busy(busy), .warn(warn),
  .warnAddr(warnAddr), .warnPc(warnPc)
);

// File: tb/test_rbw_monitor.sv
module test_rbw_monitor;
  localparam int ADDR_W = 20;
  localparam int PC_W   = 16;
  localparam int LIMIT  = 'h1F800;
  localparam int WORD_W = 64;
  localparam int NWORDS = LIMIT / WORD_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, clrReq = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0, wrAddr = '0;
  logic [PC_W-1:0] pc = '0;
  logic busy, warn;
  logic [ADDR_W-1:0] warnAddr;
  logic [PC_W-1:0] warnPc;

  always #2 clk = ~clk;

  rbw_monitor #(.ADDR_W(ADDR_W), .PC_W(PC_W), .TRACK_LIMIT(LIMIT), .WORD_W(WORD_W))
  i_rbw_monitor (
    .clk(clk), .rst(rst), .enable(enable), .clrReq(clrReq),
    .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn), .wrAddr(wrAddr), .pc(pc),
    .busy(busy), .warn(warn), .warnAddr(warnAddr), .warnPc(warnPc)
  );

  // behavioural reference
  bit marked [int];
  int sweepLeft = 0;
  bit expWarn = 1'b0;
  int expAddr = 0, expPc = 0;
  bit active;

  int tests = 0, fails = 0, cycles = 0;
  string tag = "R6";
  bit done = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      marked.delete();
      sweepLeft = NWORDS;
      expWarn = 1'b0; expAddr = 0; expPc = 0;
    end else begin
      active = enable && (sweepLeft == 0);
      expWarn = 1'b0;
      if (active && rdEn && int'(rdAddr) < LIMIT && !marked.exists(int'(rdAddr))
          && !(wrEn && wrAddr == rdAddr)) begin
        expWarn = 1'b1; expAddr = int'(rdAddr); expPc = int'(pc);
      end
      if (active && wrEn && int'(wrAddr) < LIMIT) marked[int'(wrAddr)] = 1'b1;
      if (clrReq) begin
        marked.delete();
        sweepLeft = NWORDS;
      end else if (sweepLeft > 0) sweepLeft--;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(busy == (sweepLeft > 0), "busy", int'(busy), int'(sweepLeft > 0));
      check(warn == expWarn, "warn", int'(warn), int'(expWarn));
      check(int'(warnAddr) == expAddr && int'(warnPc) == expPc, "warnAddr/warnPc",
            int'(warnAddr), expAddr);
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles >= 150000 && !done) begin
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    finishRun();
  end

  task automatic cyc(input bit r, input int ra, input bit w, input int wa, input int p);
    rdEn = r; rdAddr = ADDR_W'(ra); wrEn = w; wrAddr = ADDR_W'(wa); pc = PC_W'(p);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitSweep();
    int n = 0;
    while (busy && n < 3 * NWORDS) begin @(negedge clk); n++; end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R6";
    check(warn == 1'b0 && warnAddr == '0 && warnPc == '0, "reset outputs", int'(warn), 0);
    rst = 1'b0;
    waitSweep();
    enable = 1'b1;
    idle(1);

    tag = "R3";  cyc(1, 'h00100, 0, 0, 'h1234); idle(1);
    tag = "R9";  idle(2);
    tag = "R2";  cyc(0, 0, 1, 'h00200, 0); cyc(1, 'h00200, 0, 0, 'h1); idle(1);
    tag = "R10"; cyc(0, 0, 1, 'h00300, 0); cyc(1, 'h00301, 0, 0, 'h2);
                 cyc(1, 'h002FF, 0, 0, 'h3); cyc(1, 'h00300, 0, 0, 'h4); idle(1);
    tag = "R4";  cyc(1, LIMIT - 1, 0, 0, 'h5); cyc(0, 0, 1, LIMIT - 1, 0);
                 cyc(1, LIMIT - 1, 0, 0, 'h6); cyc(1, 0, 0, 0, 'h7);
                 cyc(0, 0, 1, 0, 0); cyc(1, 0, 0, 0, 'h8); idle(1);
    tag = "R1";  cyc(1, LIMIT, 0, 0, 'h9); cyc(1, 'hFFFFF, 0, 0, 'hA);
                 cyc(0, 0, 1, LIMIT, 0); cyc(1, LIMIT, 0, 0, 'hB); idle(1);
    tag = "R8";  cyc(1, 'h00400, 1, 'h00400, 'hC); cyc(1, 'h00400, 0, 0, 'hD);
                 cyc(1, 'h00401, 1, 'h00402, 'hE); idle(1);
    tag = "R5";  enable = 1'b0; idle(1);
                 cyc(1, 'h00500, 0, 0, 'hF); cyc(0, 0, 1, 'h00600, 0);
                 enable = 1'b1; idle(1);
                 cyc(1, 'h00600, 0, 0, 'h10); idle(1);
    tag = "R7";  clrReq = 1'b1; @(negedge clk); clrReq = 1'b0;
                 cyc(0, 0, 1, 'h00700, 0); cyc(1, 'h00800, 0, 0, 'h11);
                 waitSweep(); idle(1);
                 cyc(1, 'h00200, 0, 0, 'h12); cyc(1, 'h00700, 0, 0, 'h13); idle(1);
    tag = "R6";  cyc(0, 0, 1, 'h00900, 0);
                 rst = 1'b1; idle(2); rst = 1'b0;
                 waitSweep(); idle(1);
                 cyc(1, 'h00900, 0, 0, 'h14); idle(1);
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      int ra = int'($urandom_range(0, 200));
      int wa = int'($urandom_range(0, 200));
      bit r  = 1'($urandom_range(0, 1));
      bit w  = 1'($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 9) == 0) ra = LIMIT - 100 + ra;
      cyc(r, ra, w, wa, int'($urandom_range(0, 65535)));
    end
    idle(2);
    finishRun();
  end
endmodule